// File: doc/BRIEF.md
# Paged EEPROM address and write engine

This block is the memory-side controller behind a two-wire serial front end for a 2048 x 8 non-volatile array. The front end turns the line protocol into events: START, STOP, received bytes, and requests for the next byte to transmit. The engine decodes the control byte and keeps an 11-bit word address counter. It collects write data in a 16-byte page buffer and answers read requests from a synchronous RAM that stands in for the array.

The address counter moves differently in each direction. A written byte advances only the in-page offset, which wraps inside the 16-byte page. A read byte advances the full address, which wraps from the top of the array to byte 0. A STOP after at least one data byte starts a timed internal write cycle. During that cycle the buffered bytes are copied into the RAM one per clock and the block reports busy. A high write-protect input still lets address and data bytes be acknowledged, but the STOP then does not start a write cycle.

Top module: `eepe_engine`

## Requirements
- R1: A control byte is acknowledged only when its upper nibble is 1010. Any other control byte, and every byte after it, is answered with a NACK until the next START, and the address counter is left unchanged.
- R2: A write control byte (bit 0 = 0) loads its bits [3:1] into address bits [10:8]. The following word-address byte loads address bits [7:0]. Both bytes are acknowledged.
- R3: Each write data byte is acknowledged and buffered at the current in-page offset, which is address bits [3:0]. Only bits [3:0] then increment, wrapping from 15 to 0, while bits [10:4] stay fixed.
- R4: A STOP that follows at least one data byte, with write protect low, raises busy from the next clock for exactly WR_CYCLES clocks. Only the offsets that received data are written into the page. The other bytes of that page keep their values.
- R5: A STOP after a write control byte and word-address byte, with no data byte, starts no write cycle and leaves the loaded address in place.
- R6: When more than 16 data bytes arrive before STOP, the later bytes replace the earlier buffered bytes at the same offsets. Only the last value at each offset is committed.
- R7: In a read, each request returns the byte at the current address with rd_valid one clock later. The full 11-bit address then increments, wrapping from 2047 to 0.
- R8: The address counter keeps its value between transactions. A read control byte (bit 0 = 1) starts a current-address read from the address that follows the last byte accessed.
- R9: A repeated START after the word-address byte, followed by a read control byte, reads from the loaded address without writing anything.
- R10: With write protect high, control, address and data bytes are still acknowledged, but STOP starts no write cycle. Busy stays low and the array is unchanged.
- R11: While busy, every received byte gets a NACK, START, STOP and read requests are ignored, and no read data is returned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Pulse: START or repeated START seen on the bus |
| stop_i | input | 1 | Pulse: STOP seen on the bus |
| byte_valid_i | input | 1 | Pulse: a byte was received from the bus master |
| byte_i | input | 8 | Received byte |
| ack_valid_o | output | 1 | One clock after byte_valid_i: acknowledge decision is valid |
| ack_o | output | 1 | 1 = acknowledge the byte, 0 = NACK |
| rd_req_i | input | 1 | Pulse: the front end needs the next byte to transmit |
| rd_valid_o | output | 1 | Read byte on rd_data_o is valid |
| rd_data_o | output | 8 | Byte to transmit |
| wp_i | input | 1 | Write protect, high protects the whole array |
| busy_o | output | 1 | Internal write cycle in progress |
| mem_addr_o | output | AW | Array RAM address |
| mem_we_o | output | 1 | Array RAM write enable |
| mem_wdata_o | output | 8 | Array RAM write data |
| mem_rdata_i | input | 8 | Array RAM read data, one clock after the address |

## Verification
The engine is driven with these transaction patterns:
- partial page writes starting mid-page, which separate committed offsets from untouched neighbours;
- a write that crosses offset 15, which shows whether the offset wraps inside the page or spills into the next page;
- a 20-byte write, which tells overwrite-in-buffer apart from a larger buffer;
- address-only and write-protected writes, which must leave busy low;
- random, current-address and sequential reads across the array top, which separate the full-width read increment from the write increment.

A reference model holds its own copy of the array and the address. The busy level is compared against that model on every clock, so a write cycle one clock too short or too long is caught. A rejected control byte and traffic sent during busy check that the address and array are left untouched.

// File: rtl/eepe_pkg.sv
package eepe_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CTRL,
        ST_WADDR,
        ST_WDATA,
        ST_RDATA
    } eng_state_e;

    localparam logic [3:0] CTRL_TAG = 4'b1010;
endpackage

// File: rtl/eepe_page_buf.sv
module eepe_page_buf #(
    parameter int PAGE_BYTES = 16,
    parameter int OFFW       = $clog2(PAGE_BYTES)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr_i,
    input  logic            wr_i,
    input  logic [OFFW-1:0] wr_off_i,
    input  logic [7:0]      wr_data_i,
    input  logic [OFFW-1:0] rd_off_i,
    output logic [7:0]      rd_data_o,
    output logic            rd_hit_o,
    output logic            any_o
);
    logic [PAGE_BYTES-1:0][7:0] dat_d, dat_q;
    logic [PAGE_BYTES-1:0]      msk_d, msk_q;

    always_comb begin
        dat_d = dat_q;
        msk_d = msk_q;
        if (clr_i) msk_d = '0;
        for (int i = 0; i < PAGE_BYTES; i++) begin
            if (wr_i && (wr_off_i == OFFW'(i))) begin
                dat_d[i] = wr_data_i;
                msk_d[i] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dat_q <= '0;
            msk_q <= '0;
        end else begin
            dat_q <= dat_d;
            msk_q <= msk_d;
        end
    end

    assign rd_data_o = dat_q[rd_off_i];
    assign rd_hit_o  = msk_q[rd_off_i];
    assign any_o     = |msk_q;

    assert_clear_empties_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !wr_i) |=> !any_o);
    assert_write_marks_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && !clr_i) |=> any_o);
endmodule

// File: rtl/eepe_commit_timer.sv
module eepe_commit_timer #(
    parameter int CYCLES     = 40,
    parameter int PAGE_BYTES = 16,
    parameter int OFFW       = $clog2(PAGE_BYTES)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            go_i,
    output logic            busy_o,
    output logic [OFFW-1:0] slot_o,
    output logic            slot_live_o
);
    localparam int CW = $clog2(CYCLES + 1);

    logic [CW-1:0] cnt_d, cnt_q;
    logic          run_d, run_q;

    always_comb begin
        cnt_d = cnt_q;
        run_d = run_q;
        if (run_q) begin
            if (cnt_q == CW'(CYCLES - 1)) begin
                run_d = 1'b0;
                cnt_d = '0;
            end else begin
                cnt_d = cnt_q + 1'b1;
            end
        end else if (go_i) begin
            run_d = 1'b1;
            cnt_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            run_q <= 1'b0;
        end else begin
            cnt_q <= cnt_d;
            run_q <= run_d;
        end
    end

    assign busy_o      = run_q;
    assign slot_o      = cnt_q[OFFW-1:0];
    assign slot_live_o = run_q && (cnt_q < CW'(PAGE_BYTES));

    assert_count_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        run_q |-> (cnt_q < CW'(CYCLES)));
    assert_go_starts_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (go_i && !run_q) |=> (run_q && cnt_q == '0));
endmodule

// File: rtl/eepe_engine.sv
module eepe_engine
    import eepe_pkg::*;
#(
    parameter int AW         = 11,
    parameter int PAGE_BYTES = 16,
    parameter int WR_CYCLES  = 40
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          stop_i,
    input  logic          byte_valid_i,
    input  logic [7:0]    byte_i,
    output logic          ack_valid_o,
    output logic          ack_o,
    input  logic          rd_req_i,
    output logic          rd_valid_o,
    output logic [7:0]    rd_data_o,
    input  logic          wp_i,
    output logic          busy_o,
    output logic [AW-1:0] mem_addr_o,
    output logic          mem_we_o,
    output logic [7:0]    mem_wdata_o,
    input  logic [7:0]    mem_rdata_i
);
    localparam int OFFW  = $clog2(PAGE_BYTES);
    localparam int PSELW = AW - 8;

    typedef struct packed {
        eng_state_e    st;
        logic [AW-1:0] addr;
        logic          ack_v;
        logic          ack;
        logic          rd_v;
    } regs_t;

    regs_t r_d, r_q;

    logic            buf_clr, buf_wr, wr_go;
    logic            busy, slot_live, buf_hit, buf_any;
    logic [OFFW-1:0] slot;
    logic [7:0]      buf_byte;

    eepe_page_buf #(.PAGE_BYTES(PAGE_BYTES), .OFFW(OFFW)) u_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_i     (buf_clr),
        .wr_i      (buf_wr),
        .wr_off_i  (r_q.addr[OFFW-1:0]),
        .wr_data_i (byte_i),
        .rd_off_i  (slot),
        .rd_data_o (buf_byte),
        .rd_hit_o  (buf_hit),
        .any_o     (buf_any)
    );

    eepe_commit_timer #(.CYCLES(WR_CYCLES), .PAGE_BYTES(PAGE_BYTES), .OFFW(OFFW)) u_tmr (
        .clk         (clk),
        .rst_n       (rst_n),
        .go_i        (wr_go),
        .busy_o      (busy),
        .slot_o      (slot),
        .slot_live_o (slot_live)
    );

    always_comb begin
        r_d       = r_q;
        r_d.ack_v = byte_valid_i;
        r_d.ack   = 1'b0;
        r_d.rd_v  = 1'b0;
        buf_clr   = 1'b0;
        buf_wr    = 1'b0;
        wr_go     = 1'b0;
        if (!busy) begin
            if (start_i) begin
                r_d.st = ST_CTRL;
            end else if (stop_i) begin
                if (r_q.st == ST_WDATA && buf_any && !wp_i) wr_go = 1'b1;
                r_d.st = ST_IDLE;
            end else if (byte_valid_i) begin
                case (r_q.st)
                    ST_CTRL: begin
                        if (byte_i[7:4] == CTRL_TAG) begin
                            r_d.ack = 1'b1;
                            if (byte_i[0]) begin
                                r_d.st = ST_RDATA;
                            end else begin
                                r_d.st             = ST_WADDR;
                                r_d.addr[AW-1:8]   = byte_i[PSELW:1];
                                buf_clr            = 1'b1;
                            end
                        end else begin
                            r_d.st = ST_IDLE;
                        end
                    end
                    ST_WADDR: begin
                        r_d.ack       = 1'b1;
                        r_d.addr[7:0] = byte_i;
                        r_d.st        = ST_WDATA;
                    end
                    ST_WDATA: begin
                        r_d.ack              = 1'b1;
                        buf_wr               = 1'b1;
                        r_d.addr[OFFW-1:0]   = r_q.addr[OFFW-1:0] + 1'b1;
                    end
                    default: ;
                endcase
            end else if (rd_req_i && r_q.st == ST_RDATA) begin
                r_d.rd_v = 1'b1;
                r_d.addr = r_q.addr + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, addr: '0, ack_v: 1'b0, ack: 1'b0, rd_v: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign ack_valid_o = r_q.ack_v;
    assign ack_o       = r_q.ack;
    assign rd_valid_o  = r_q.rd_v;
    assign rd_data_o   = mem_rdata_i;
    assign busy_o      = busy;
    assign mem_addr_o  = busy ? {r_q.addr[AW-1:OFFW], slot} : r_q.addr;
    assign mem_we_o    = slot_live && buf_hit;
    assign mem_wdata_o = buf_byte;

    assert_busy_nack_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_valid_o && $past(busy_o)) |-> !ack_o);
    assert_busy_no_read_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> !rd_valid_o);
    assert_we_only_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_o |-> (busy_o && mem_addr_o[AW-1:OFFW] == r_q.addr[AW-1:OFFW]));
    assert_protect_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(!wp_i && stop_i));
    assert_page_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_WDATA && byte_valid_i && !busy_o && !start_i && !stop_i) |=>
        (r_q.addr[AW-1:OFFW] == $past(r_q.addr[AW-1:OFFW]) &&
         r_q.addr[OFFW-1:0] == OFFW'($past(r_q.addr[OFFW-1:0]) + 1'b1)));
    assert_read_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_RDATA && rd_req_i && !busy_o && !start_i && !stop_i && !byte_valid_i) |=>
        (rd_valid_o && r_q.addr == AW'($past(r_q.addr) + 1'b1)));
endmodule

// File: tb/sim_eepe_engine.sv
module sim_eepe_engine;
    localparam int AW = 11;
    localparam int WR = 40;
    localparam int NB = 2048;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 0, stop_i = 0, byte_valid_i = 0, rd_req_i = 0, wp_i = 0;
    logic [7:0] byte_i = '0;
    logic ack_valid_o, ack_o, rd_valid_o, busy_o, mem_we_o;
    logic [7:0] rd_data_o, mem_wdata_o;
    logic [7:0] mem_rdata_i = '0;
    logic [AW-1:0] mem_addr_o;

    always #10 clk = ~clk;

    eepe_engine #(.AW(AW), .PAGE_BYTES(16), .WR_CYCLES(WR)) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
        .byte_valid_i(byte_valid_i), .byte_i(byte_i), .ack_valid_o(ack_valid_o),
        .ack_o(ack_o), .rd_req_i(rd_req_i), .rd_valid_o(rd_valid_o),
        .rd_data_o(rd_data_o), .wp_i(wp_i), .busy_o(busy_o),
        .mem_addr_o(mem_addr_o), .mem_we_o(mem_we_o), .mem_wdata_o(mem_wdata_o),
        .mem_rdata_i(mem_rdata_i)
    );

    logic [7:0] ram [0:NB-1];
    always @(posedge clk) begin
        if (mem_we_o) ram[mem_addr_o] <= mem_wdata_o;
        mem_rdata_i <= ram[mem_addr_o];
    end

    // reference model state
    int ref_mem [0:NB-1];
    int ref_addr = 0;
    int busy_left = 0;
    int pend_d [0:15];
    bit pend_m [0:15];
    int vecs = 0, errs = 0, cycles = 0;
    bit live = 0;
    bit done = 0;

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        vecs++;
        if (got !== exp) begin
            errs++;
            $display("FAIL %s got %0h exp %0h", req, got, exp);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
            $finish;
        end
    endtask

    // per-clock comparison of busy against the model, plus watchdog
    always @(negedge clk) begin
        cycles++;
        if (live) begin
            chk("R4 R10 busy level", {31'd0, busy_o}, {31'd0, busy_left > 0});
            if (busy_left > 0) busy_left--;
        end
        if (cycles > 150000) begin
            errs++;
            $display("FAIL watchdog got %0d exp <150000", cycles);
            summary();
        end
    end

    task automatic do_start();
        @(negedge clk) start_i = 1;
        @(negedge clk) start_i = 0;
    endtask

    task automatic do_stop(input bit commit);
        @(negedge clk) stop_i = 1;
        @(posedge clk);
        #1;
        if (commit) busy_left = WR;
        @(negedge clk) stop_i = 0;
    endtask

    task automatic send(input logic [7:0] b, input bit exp_ack, input string req);
        @(negedge clk) begin byte_valid_i = 1; byte_i = b; end
        @(negedge clk) byte_valid_i = 0;
        chk(req, {30'd0, ack_valid_o, ack_o}, {30'd0, 1'b1, exp_ack});
    endtask

    task automatic rd_one(input bit exp_v, input string req);
        @(negedge clk) rd_req_i = 1;
        @(negedge clk) rd_req_i = 0;
        chk(req, {31'd0, rd_valid_o}, {31'd0, exp_v});
        if (exp_v) begin
            chk(req, {24'd0, rd_data_o}, ref_mem[ref_addr][31:0]);
            ref_addr = (ref_addr + 1) % NB;
        end
    endtask

    function automatic logic [7:0] wctrl(input int a);
        return 8'hA0 | 8'((a >> 8) & 7) << 1;
    endfunction

    task automatic wait_idle();
        while (busy_left > 0) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic write_txn(input int a, input int n, input int seed, input bit prot);
        int pg;
        int off;
        pg = a & ~15;
        off = a & 15;
        for (int i = 0; i < 16; i++) pend_m[i] = 0;
        wp_i = prot;
        do_start();
        send(wctrl(a), 1, "R2 write ctrl");
        send(8'(a), 1, "R2 word addr");
        for (int i = 0; i < n; i++) begin
            send(8'(seed + i * 13), 1, "R3 data ack");
            pend_d[off] = (seed + i * 13) & 255;
            pend_m[off] = 1;
            off = (off + 1) % 16;
        end
        ref_addr = pg | off;
        do_stop(n > 0 && !prot);
        if (n > 0 && !prot)
            for (int i = 0; i < 16; i++) if (pend_m[i]) ref_mem[pg + i] = pend_d[i];
    endtask

    task automatic rand_read(input int a, input int n, input string req);
        do_start();
        send(wctrl(a), 1, "R2 dummy ctrl");
        send(8'(a), 1, "R2 dummy addr");
        ref_addr = a;
        do_start();
        send(8'hA1, 1, "R9 read ctrl");
        for (int i = 0; i < n; i++) rd_one(1, req);
        do_stop(0);
    endtask

    task automatic cur_read(input int n, input string req);
        do_start();
        send(8'hA1, 1, "R8 read ctrl");
        for (int i = 0; i < n; i++) rd_one(1, req);
        do_stop(0);
    endtask

    initial begin
        for (int i = 0; i < NB; i++) begin
            ram[i] = 8'((i * 7 + 3) ^ (i >> 3));
            ref_mem[i] = ((i * 7 + 3) ^ (i >> 3)) & 255;
        end
        repeat (3) @(negedge clk);
        chk("reset busy", {31'd0, busy_o}, 0);
        chk("reset ack_valid", {31'd0, ack_valid_o}, 0);
        chk("reset rd_valid", {31'd0, rd_valid_o}, 0);
        rst_n = 1;
        @(negedge clk);
        live = 1;

        rand_read(12'h005, 4, "R7 R9 random read");

        write_txn(12'h123, 3, 8'h40, 0);
        chk("R8 addr after write", ref_addr, 32'h126);
        wait_idle();
        rand_read(12'h120, 16, "R4 partial page");
        cur_read(2, "R8 current read");

        write_txn(12'h25E, 5, 8'h11, 0);
        wait_idle();
        rand_read(12'h250, 16, "R3 in-page wrap");

        write_txn(12'h300, 20, 8'h77, 0);
        // traffic during the write cycle must be ignored
        do_start();
        send(8'hA0, 0, "R11 busy nack");
        rd_one(0, "R11 busy read");
        @(negedge clk) stop_i = 1;
        @(negedge clk) stop_i = 0;
        wait_idle();
        rand_read(12'h300, 16, "R6 buffer overwrite");

        write_txn(12'h400, 0, 0, 0);
        repeat (4) @(negedge clk);
        cur_read(1, "R5 address-only write");

        write_txn(12'h530, 4, 8'h99, 1);
        repeat (WR + 4) @(negedge clk);
        wp_i = 0;
        rand_read(12'h530, 6, "R10 protected page");

        do_start();
        send(8'h52, 0, "R1 bad ctrl");
        send(8'h11, 0, "R1 ignored byte");
        do_stop(0);
        cur_read(1, "R1 addr unchanged");

        rand_read(12'h7FE, 4, "R7 array wrap");
        cur_read(1, "R8 after wrap");

        repeat (4) @(negedge clk);
        summary();
    end
endmodule